// File: doc/BRIEF.md
# In-Band Scan Channel Router

This block sits between a small set of tester scan channels and a larger set of core scan channels. Each tester channel feeds an input demultiplexer that steers its stimulus onto one core scan input. Each tester output is fed by an output multiplexer that picks one core scan output. The routing is not set through a side port. It travels in the scan stream itself. The last few bits shifted into each tester channel before the end-of-pattern strobe form a control word. That word is held in a short per-channel pipeline, and the scan data passes through the same pipeline on its way to the cores.

When the end-of-pattern strobe arrives, the control words in the pipelines are copied into shadow registers, and only the shadow registers drive the multiplexers. The routing therefore stays fixed while a pattern shifts. A configuration sent with one pattern governs the next pattern. The first pattern after reset only sets up the routing. Because every pattern carries its own control word, the sequence of configurations has no length limit.

With the default sizes there are four tester channels and six core channels, and each tester channel carries a three-bit steering code and a three-bit observe code.

Top module: `scan_chan_router`

## Requirements
- R1: While reset is high and after it, every shadow code is 0, every core scan input is 0 and every tester output is 0, whatever the other inputs are.
- R2: Each tester channel passes through a pipeline of CTRL = N_IN + N_OUT stages. On a shift edge a core scan input takes the bit that its source tester channel received CTRL shift edges earlier, so the bit shifted on shift edge j appears on the core input after shift edge j + CTRL.
- R3: On an end-of-pattern strobe each channel captures its last CTRL shifted bits as its control word. The first N_IN bits shifted, most significant bit first, form the steering code. The last N_OUT bits form the observe code.
- R4: Shadow codes change only on an end-of-pattern strobe. Any amount of shifting without the strobe leaves the routing unchanged.
- R5: Steering code k with 1 <= k <= N_CORE sends the channel's pipeline output to core input k-1. Code 0 and codes above N_CORE disconnect the channel. A core input that no channel selects takes 0 on each shift edge.
- R6: When several tester channels select the same core input, the channel with the lowest index drives it.
- R7: On every clock each tester output registers core output k-1 for an observe code k with 1 <= k <= N_CORE, and 0 for code 0 or codes above N_CORE.
- R8: When the strobe and a shift coincide, the shadow codes take the pipeline contents from before that shift, and the core inputs updated on that edge still use the previous routing.
- R9: A configuration takes effect only for the pattern after the one that carried it. The first pattern after reset sees every core disconnected.
- R10: With shift enable low, the pipelines and the core scan inputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advances the pipelines and the core scan inputs |
| eop | input | 1 | End-of-pattern strobe; loads the shadow codes |
| tin | input | N_TST | Tester scan inputs |
| core_si | output | N_CORE | Registered scan inputs to the cores |
| core_so | input | N_CORE | Scan outputs from the cores |
| tout | output | N_TST | Registered tester scan outputs |

## Verification
The end-of-pattern strobe can arrive on the same edge as a shift. In that case the shadow capture and the shift of the data through the pipeline, which moves the control word one place, fall in one cycle. The bench provokes this by shifting a full control word and then raising the strobe and shift enable together with one extra data bit. The scoreboard then expects the routing set by that word, not by the word moved one place. It also expects the core inputs written on that very edge to follow the old routing. The same scoreboard checks that long runs of shifting without the strobe, including runs with gaps in shift enable, never disturb the observed routing.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

  // A code addresses core (code-1); zero and codes past the last core are idle.
  function automatic logic code_live(input int unsigned code, input int unsigned ncore);
    return (code != 0) && (code <= ncore);
  endfunction

  function automatic logic code_picks(input int unsigned code, input int unsigned core,
                                      input int unsigned ncore);
    return code_live(code, ncore) && (code == core + 1);
  endfunction

endpackage

// File: rtl/scr_ctrl_pipe.sv
`timescale 1ns/1ps
module scr_ctrl_pipe #(
  parameter int CTRL = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [CTRL-1:0] stages,
  output logic            top
);

  // stages[0] holds the newest bit, stages[CTRL-1] the oldest
  always_ff @(posedge clk) begin
    if (rst)
      stages <= '0;
    else if (shift_en)
      stages <= {stages[CTRL-2:0], din};
  end

  assign top = stages[CTRL-1];

  // R10
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stages));

endmodule

// File: rtl/scr_shadow.sv
`timescale 1ns/1ps
module scr_shadow #(
  parameter int N_TST = 4,
  parameter int N_IN  = 3,
  parameter int N_OUT = 3,
  localparam int CTRL = N_IN + N_OUT
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         eop,
  input  logic [N_TST-1:0][CTRL-1:0]   words,
  output logic [N_TST-1:0][N_IN-1:0]   dsel,
  output logic [N_TST-1:0][N_OUT-1:0]  msel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dsel <= '0;
      msel <= '0;
    end else if (eop) begin
      for (int i = 0; i < N_TST; i++) begin
        dsel[i] <= words[i][CTRL-1 -: N_IN];
        msel[i] <= words[i][N_OUT-1:0];
      end
    end
  end

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eop |=> ($stable(dsel) && $stable(msel)));

  generate
    for (genvar g = 0; g < N_TST; g++) begin : g_cap
      // R3
      capture_chk: assert property (@(posedge clk) disable iff (rst)
        eop |=> ({dsel[g], msel[g]} == $past(words[g])));
    end
  endgenerate

endmodule

// File: rtl/scr_in_demux.sv
`timescale 1ns/1ps
module scr_in_demux #(
  parameter int N_TST  = 4,
  parameter int N_CORE = 6,
  parameter int N_IN   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift_en,
  input  logic [N_TST-1:0]            tops,
  input  logic [N_TST-1:0][N_IN-1:0]  dsel,
  output logic [N_CORE-1:0]           core_si
);

  logic [N_CORE-1:0] nxt;
  logic [N_CORE-1:0] hit;

  // lowest tester index wins a contested core
  always_comb begin
    nxt = '0;
    hit = '0;
    for (int c = 0; c < N_CORE; c++) begin
      for (int i = 0; i < N_TST; i++) begin
        if (!hit[c] && scr_pkg::code_picks(32'(dsel[i]), 32'(c), N_CORE)) begin
          nxt[c] = tops[i];
          hit[c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      core_si <= '0;
    else if (shift_en)
      core_si <= nxt;
  end

  // R10
  core_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(core_si));

  generate
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
      // R5
      idle_core_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !hit[c]) |=> !core_si[c]);
      // R6
      first_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && scr_pkg::code_picks(32'(dsel[0]), 32'(c), N_CORE))
          |=> (core_si[c] == $past(tops[0])));
    end
  endgenerate

endmodule

// File: rtl/scr_out_mux.sv
`timescale 1ns/1ps
module scr_out_mux #(
  parameter int N_TST  = 4,
  parameter int N_CORE = 6,
  parameter int N_OUT  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CORE-1:0]            core_so,
  input  logic [N_TST-1:0][N_OUT-1:0]  msel,
  output logic [N_TST-1:0]             tout
);

  logic [N_TST-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_TST; i++) begin
      for (int c = 0; c < N_CORE; c++) begin
        if (scr_pkg::code_picks(32'(msel[i]), 32'(c), N_CORE))
          pick[i] = core_so[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      tout <= '0;
    else
      tout <= pick;
  end

  generate
    for (genvar i = 0; i < N_TST; i++) begin : g_tst
      // R7
      idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !scr_pkg::code_live(32'(msel[i]), N_CORE) |=> !tout[i]);
      for (genvar c = 0; c < N_CORE; c++) begin : g_src
        // R7
        observe_chk: assert property (@(posedge clk) disable iff (rst)
          scr_pkg::code_picks(32'(msel[i]), 32'(c), N_CORE)
            |=> (tout[i] == $past(core_so[c])));
      end
    end
  endgenerate

endmodule

// File: rtl/scan_chan_router.sv
`timescale 1ns/1ps
module scan_chan_router #(
  parameter int N_TST  = 4,
  parameter int N_CORE = 6,
  parameter int N_IN   = 3,
  parameter int N_OUT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              eop,
  input  logic [N_TST-1:0]  tin,
  output logic [N_CORE-1:0] core_si,
  input  logic [N_CORE-1:0] core_so,
  output logic [N_TST-1:0]  tout
);

  localparam int CTRL = N_IN + N_OUT;

  logic [N_TST-1:0][CTRL-1:0]  words;
  logic [N_TST-1:0]            tops;
  logic [N_TST-1:0][N_IN-1:0]  dsel;
  logic [N_TST-1:0][N_OUT-1:0] msel;

  generate
    for (genvar i = 0; i < N_TST; i++) begin : g_chan
      scr_ctrl_pipe #(.CTRL(CTRL)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (tin[i]),
        .stages   (words[i]),
        .top      (tops[i])
      );
    end
  endgenerate

  scr_shadow #(.N_TST(N_TST), .N_IN(N_IN), .N_OUT(N_OUT)) u_shadow (
    .clk   (clk),
    .rst   (rst),
    .eop   (eop),
    .words (words),
    .dsel  (dsel),
    .msel  (msel)
  );

  scr_in_demux #(.N_TST(N_TST), .N_CORE(N_CORE), .N_IN(N_IN)) u_demux (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .tops     (tops),
    .dsel     (dsel),
    .core_si  (core_si)
  );

  scr_out_mux #(.N_TST(N_TST), .N_CORE(N_CORE), .N_OUT(N_OUT)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .core_so (core_so),
    .msel    (msel),
    .tout    (tout)
  );

endmodule

// File: tb/tb_scan_chan_router.sv
`timescale 1ns/1ps
module tb_scan_chan_router;
  localparam int NT = 4, NC = 6, NI = 3, NO = 3, CB = NI + NO;

  logic clk = 1'b0, rst = 1'b1, shift_en = 1'b0, eop = 1'b0;
  logic [NT-1:0] tin = '0;
  logic [NT-1:0] tout;
  logic [NC-1:0] core_si;
  logic [NC-1:0] core_so = '0;

  always #2.5 clk = ~clk;

  scan_chan_router #(.N_TST(NT), .N_CORE(NC), .N_IN(NI), .N_OUT(NO)) dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .eop(eop), .tin(tin),
    .core_si(core_si), .core_so(core_so), .tout(tout)
  );

  typedef struct { logic [NC-1:0] si; logic [NT-1:0] to; string tag; } item_t;
  item_t sbq[$];
  int n_chk = 0, n_fail = 0;

  logic [CB-1:0] m_stage [NT];
  int            m_dsel  [NT];
  int            m_msel  [NT];
  logic [NC-1:0] m_si = '0;
  logic [15:0]   rs = 16'hACE1;

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [CB-1:0] mk(input int d, input int m);
    return {NI'(d), NO'(m)};
  endfunction

  // driver: applies one cycle and pushes what the ports must show after it
  task automatic step(input logic [NT-1:0] t, input logic sh, input logic e,
                      input logic [NC-1:0] so, input string tag);
    item_t it;
    logic [NT-1:0] to_e;
    bit found;
    @(negedge clk);
    tin = t; shift_en = sh; eop = e; core_so = so;
    @(posedge clk);
    #1;
    if (sh) begin
      for (int c = 0; c < NC; c++) begin
        found = 0;
        m_si[c] = 1'b0;
        for (int i = 0; i < NT; i++)
          if (!found && m_dsel[i] == c + 1) begin
            m_si[c] = m_stage[i][CB-1];
            found = 1;
          end
      end
    end
    for (int i = 0; i < NT; i++)
      to_e[i] = (m_msel[i] >= 1 && m_msel[i] <= NC) ? so[m_msel[i]-1] : 1'b0;
    if (e)
      for (int i = 0; i < NT; i++) begin
        m_dsel[i] = int'(m_stage[i][CB-1 -: NI]);
        m_msel[i] = int'(m_stage[i][NO-1:0]);
      end
    if (sh)
      for (int i = 0; i < NT; i++) m_stage[i] = {m_stage[i][CB-2:0], t[i]};
    it.si = m_si; it.to = to_e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic rand_step(input logic sh, input logic e, input string tag);
    logic [15:0] a;
    rs = lfsr_next(rs); a = rs;
    rs = lfsr_next(rs);
    step(a[NT-1:0], sh, e, NC'(rs >> 3), tag);
  endtask

  task automatic send_pattern(input logic [NT-1:0][CB-1:0] w, input int ndata,
                              input logic eop_with_shift, input string tag);
    logic [NT-1:0] t;
    for (int k = 0; k < ndata; k++) rand_step(1'b1, 1'b0, tag);
    for (int k = 0; k < CB; k++) begin
      for (int i = 0; i < NT; i++) t[i] = w[i][CB-1-k];
      rs = lfsr_next(rs);
      step(t, 1'b1, 1'b0, NC'(rs), tag);
    end
    rand_step(eop_with_shift, 1'b1, tag);
  endtask

  // monitor: compares the ports against the queue away from the clock edge
  initial forever begin
    @(negedge clk);
    while (sbq.size() != 0) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (core_si !== it.si) begin
        n_fail++;
        $display("FAIL %s core_si got %b expected %b", it.tag, core_si, it.si);
      end
      n_chk++;
      if (tout !== it.to) begin
        n_fail++;
        $display("FAIL %s tout got %b expected %b", it.tag, tout, it.to);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NT-1:0][CB-1:0] w;
    for (int i = 0; i < NT; i++) begin m_stage[i] = '0; m_dsel[i] = 0; m_msel[i] = 0; end
    // R1: outputs stay clear under reset even with every input active
    rst = 1'b1; tin = '1; core_so = '1; shift_en = 1'b1; eop = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (core_si !== '0 || tout !== '0) begin
      n_fail++;
      $display("FAIL R1 reset got si=%b to=%b expected all zero", core_si, tout);
    end
    rst = 1'b0; tin = '0; core_so = '0; shift_en = 1'b0; eop = 1'b0;

    // R9 R1: first pattern only sets up routing; everything stays disconnected
    w[0] = mk(1, 2); w[1] = mk(3, 1); w[2] = mk(0, 0); w[3] = mk(7, 7);
    send_pattern(w, 10, 1'b0, "R9 R1 R3");
    // R2 R5 R7: routing from the first pattern, including out-of-range codes 7
    w[0] = mk(2, 3); w[1] = mk(2, 6); w[2] = mk(6, 4); w[3] = mk(5, 0);
    send_pattern(w, 12, 1'b0, "R2 R5 R7");
    // R6: channels 0 and 1 both steer to core 1
    w[0] = mk(4, 5); w[1] = mk(1, 7); w[2] = mk(3, 2); w[3] = mk(6, 1);
    send_pattern(w, 12, 1'b0, "R6 R3");
    // R10 R4: gaps in shift enable, no strobe
    for (int k = 0; k < 30; k++) begin
      rs = lfsr_next(rs);
      rand_step(rs[2], 1'b0, "R10 R4");
    end
    // R8: strobe coincides with a shift
    w[0] = mk(5, 6); w[1] = mk(5, 2); w[2] = mk(0, 3); w[3] = mk(2, 5);
    send_pattern(w, 5, 1'b1, "R8");
    for (int k = 0; k < 12; k++) rand_step(1'b1, 1'b0, "R8 R3 R6");
    // R4: long mid-pattern churn of the pipelines, routing must not move
    for (int k = 0; k < 40; k++) rand_step(1'b1, 1'b0, "R4");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule